// File: doc/BRIEF.md
# Four-Channel PS/2 Host Byte Sender

This block is the host side of a PS/2 link that reaches up to four devices through one shared shift engine. Firmware places a byte in the data register, pulls the chosen channel's data line low through a per-channel data-output bit, and then sets that channel's enable bit. The block releases the chosen clock line and holds every other clock line low. From then on the device's clock sets the pace. The block shifts out eight data bits LSB first, then an odd parity bit, then a stop bit. It then reads back the device's line-control (acknowledge) bit.

Lines are open-drain: each `*_pull` output of 1 means "drive this line low", and 0 means "release it". Raw line levels come back on the `*_i` inputs and pass through a synchronizer. Falling edges of the clock are detected in the system clock domain. Two status flags mark start and end of a transfer. They also show the channel in use and the acknowledge level. Either flag can raise the interrupt output, and firmware clears each flag by writing 1 to it.

Register map (8-bit words, `reg_addr`): 0 = byte to send; 1 = control (bits 3:0 channel enables, bit 4 start interrupt enable, bit 5 end interrupt enable); 2 = data-output bits (bits 3:0, 1 = released, reset value all ones); 3 = status (bit 0 start flag, bit 1 end flag, bit 2 acknowledge, bits 4:3 channel number).

Top module: `ps2_host_tx`

## Requirements
- R1: After reset every clock line is pulled low, every data line is released, and the status word (address 3) reads 0.
- R2: Writing address 0 stores the byte. Clearing bit c of address 2 pulls data line c low while the block is inactive, and all clock lines stay pulled low.
- R3: While inactive, writing address 1 with exactly one enable bit c set releases clock c and keeps the other clocks pulled low. An enable field with zero bits or with more than one bit set leaves all clocks pulled low. At most one clock is ever released.
- R4: A start bit is taken only from a falling edge of the active channel's clock seen while its data line is low. A falling edge while the data line is high starts nothing.
- R5: On the start bit, the block presents data bit 0 on the active data line. It sets status bit 0, writes the channel number into status bits 4:3, and sets data-output bit c back to 1.
- R6: Falling edges 2 through 8 (the start edge being edge 1) present data bits 1 through 7 in order. The active data line changes only at a falling edge of its clock.
- R7: Falling edge 9 presents odd parity: 1 when the byte holds an even number of ones.
- R8: Falling edge 10 presents a stop bit of 1. The data line then stays released.
- R9: Falling edge 11 samples the data line and ends the transfer. All clocks are pulled low and status bit 1 is set. Status bit 2 becomes 1 if the device held data low at that edge, and 0 otherwise.
- R10: The interrupt output equals (status bit 0 AND control bit 4) OR (status bit 1 AND control bit 5).
- R11: Writing 1 to status bit 0 or bit 1 clears that flag, and the interrupt it raised drops with it.
- R12: Clearing every enable bit during the request, shift or done phase returns the block to the inactive state, with all clocks pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | NCH | Raw clock line levels |
| ps2_dat_i | input | NCH | Raw data line levels |
| ps2_clk_pull | output | NCH | 1 pulls the clock line low |
| ps2_dat_pull | output | NCH | 1 pulls the data line low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: four channels, an 8-bit byte and a two-stage synchronizer. This small setup lets the bench send all 256 byte values. The channels rotate, and the acknowledge level and both interrupt enables vary from byte to byte. As a result, every parity outcome, every bit position on every channel and every interrupt combination is checked against values computed in the bench. Separate runs cover bad enable patterns, a falling edge with data high, and an abort in mid-byte.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;
   typedef enum logic [1:0] {
      ST_INACT  = 2'd0,
      ST_IDLE   = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_DONE   = 2'd3
   } ps2tx_state_e;

   localparam logic [1:0] A_BYTE = 2'd0;
   localparam logic [1:0] A_CTRL = 2'd1;
   localparam logic [1:0] A_DOUT = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
   parameter int NCH    = 4,
   parameter int STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] clk_raw,
   input  logic [NCH-1:0] dat_raw,
   output logic [NCH-1:0] dat_s,
   output logic [NCH-1:0] fall
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [STAGES-1:0] cpipe;
      logic [STAGES-1:0] dpipe;
      logic              cprev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cpipe <= '1;
            dpipe <= '1;
            cprev <= 1'b1;
         end else begin
            cpipe <= {cpipe[STAGES-2:0], clk_raw[i]};
            dpipe <= {dpipe[STAGES-2:0], dat_raw[i]};
            cprev <= cpipe[STAGES-1];
         end
      end
      assign dat_s[i] = dpipe[STAGES-1];
      assign fall[i]  = cprev & ~cpipe[STAGES-1];
   end
endmodule

// File: rtl/ps2tx_engine.sv
module ps2tx_engine
   import ps2tx_pkg::*;
#(
   parameter int NCH = 4,
   parameter int DW  = 8,
   parameter int CHW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] en,
   input  logic [DW-1:0]  tx_byte,
   input  logic [NCH-1:0] fall,
   input  logic [NCH-1:0] dat_s,
   output ps2tx_state_e   st,
   output logic [CHW-1:0] chan,
   output logic           start_p,
   output logic           done_p,
   output logic           ack_now,
   output logic           owns,
   output logic           tx_bit
);
   localparam int CNTW = $clog2(DW + 4);
   localparam logic [CNTW-1:0] C_PAR  = CNTW'(DW);
   localparam logic [CNTW-1:0] C_STOP = CNTW'(DW + 1);
   localparam logic [CNTW-1:0] C_ACK  = CNTW'(DW + 2);

   logic [CNTW-1:0] cnt;
   logic [DW-1:0]   sh;
   logic            par;
   logic            abort;
   logic            edge_a;
   logic            line_a;

   function automatic logic [CHW-1:0] enc(input logic [NCH-1:0] v);
      logic [CHW-1:0] r;
      r = '0;
      for (int k = 0; k < NCH; k++) begin
         if (v[k]) r = CHW'(k);
      end
      return r;
   endfunction

   always_comb begin
      abort   = (st != ST_INACT) && (en == '0);
      edge_a  = fall[chan];
      line_a  = dat_s[chan];
      ack_now = ~line_a;
      start_p = !abort && (st == ST_IDLE) && edge_a && !line_a;
      done_p  = !abort && (st == ST_ACTIVE) && edge_a && (cnt == C_ACK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_INACT;
         chan   <= '0;
         cnt    <= '0;
         sh     <= '0;
         par    <= 1'b0;
         owns   <= 1'b0;
         tx_bit <= 1'b1;
      end else if (abort) begin
         st   <= ST_INACT;
         owns <= 1'b0;
      end else begin
         unique case (st)
            ST_INACT: begin
               if ($onehot(en)) begin
                  st   <= ST_IDLE;
                  chan <= enc(en);
               end
            end
            ST_IDLE: begin
               if (start_p) begin
                  st     <= ST_ACTIVE;
                  owns   <= 1'b1;
                  tx_bit <= tx_byte[0];
                  sh     <= tx_byte >> 1;
                  par    <= ~^tx_byte;
                  cnt    <= CNTW'(1);
               end
            end
            ST_ACTIVE: begin
               if (edge_a) begin
                  cnt <= cnt + 1'b1;
                  if (cnt < C_PAR) begin
                     tx_bit <= sh[0];
                     sh     <= sh >> 1;
                  end else if (cnt == C_PAR) begin
                     tx_bit <= par;
                  end else if (cnt == C_STOP) begin
                     tx_bit <= 1'b1;
                  end else begin
                     st     <= ST_DONE;
                     owns   <= 1'b0;
                     tx_bit <= 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ps2tx_regs.sv
module ps2tx_regs
   import ps2tx_pkg::*;
#(
   parameter int NCH = 4,
   parameter int DW  = 8,
   parameter int CHW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [1:0]     addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata,
   input  logic           start_p,
   input  logic           done_p,
   input  logic           ack_now,
   input  logic [CHW-1:0] chan,
   output logic [NCH-1:0] en,
   output logic           sie,
   output logic           eie,
   output logic [DW-1:0]  tx_byte,
   output logic [NCH-1:0] dout,
   output logic           sot,
   output logic           eot,
   output logic [CHW-1:0] ach,
   output logic           irq
);
   logic ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= '0;
         sie     <= 1'b0;
         eie     <= 1'b0;
         tx_byte <= '0;
         dout    <= '1;
         sot     <= 1'b0;
         eot     <= 1'b0;
         ack     <= 1'b0;
         ach     <= '0;
      end else begin
         if (wr) begin
            unique case (addr)
               A_BYTE: tx_byte <= wdata;
               A_CTRL: begin
                  en  <= wdata[NCH-1:0];
                  sie <= wdata[NCH];
                  eie <= wdata[NCH+1];
               end
               A_DOUT: dout <= wdata[NCH-1:0];
               default: begin
                  if (wdata[0]) sot <= 1'b0;
                  if (wdata[1]) eot <= 1'b0;
               end
            endcase
         end
         if (start_p) begin
            sot        <= 1'b1;
            ach        <= chan;
            dout[chan] <= 1'b1;
         end
         if (done_p) begin
            eot <= 1'b1;
            ack <= ack_now;
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_BYTE: rdata = tx_byte;
         A_CTRL: begin
            rdata[NCH-1:0] = en;
            rdata[NCH]     = sie;
            rdata[NCH+1]   = eie;
         end
         A_DOUT: rdata[NCH-1:0] = dout;
         default: begin
            rdata[0]     = sot;
            rdata[1]     = eot;
            rdata[2]     = ack;
            rdata[3+:CHW] = ach;
         end
      endcase
      irq = (sot & sie) | (eot & eie);
   end
endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
   import ps2tx_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] ps2_clk_i,
   input  logic [NCH-1:0] ps2_dat_i,
   output logic [NCH-1:0] ps2_clk_pull,
   output logic [NCH-1:0] ps2_dat_pull,
   input  logic           reg_wr,
   input  logic [1:0]     reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   output logic           irq
);
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 2 || NCH > 4) begin : g_bad_nch
      $error("ps2_host_tx: NCH must be 2..4");
   end
   if (NCH + 2 > DW || 3 + CHW > DW) begin : g_bad_dw
      $error("ps2_host_tx: DW too narrow for control/status fields");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ps2_host_tx: SYNC_STAGES must be at least 2");
   end

   logic [NCH-1:0] dat_s, fall, en, dout;
   logic [DW-1:0]  tx_byte;
   logic [CHW-1:0] chan, ach;
   logic           start_p, done_p, ack_now, owns, tx_bit;
   logic           sie, eie, sot, eot;
   ps2tx_state_e   st;

   ps2tx_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .clk_raw(ps2_clk_i), .dat_raw(ps2_dat_i),
      .dat_s(dat_s), .fall(fall)
   );

   ps2tx_engine #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(en), .tx_byte(tx_byte), .fall(fall),
      .dat_s(dat_s), .st(st), .chan(chan), .start_p(start_p), .done_p(done_p),
      .ack_now(ack_now), .owns(owns), .tx_bit(tx_bit)
   );

   ps2tx_regs #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .start_p(start_p), .done_p(done_p), .ack_now(ack_now),
      .chan(chan), .en(en), .sie(sie), .eie(eie), .tx_byte(tx_byte), .dout(dout),
      .sot(sot), .eot(eot), .ach(ach), .irq(irq)
   );

   always_comb begin
      ps2_clk_pull = '1;
      if (st == ST_IDLE || st == ST_ACTIVE) ps2_clk_pull[chan] = 1'b0;
      ps2_dat_pull = ~dout;
      if (owns) ps2_dat_pull[chan] = ~tx_bit;
   end
endmodule

// File: rtl/ps2tx_chk.sv
module ps2tx_chk
   import ps2tx_pkg::*;
#(
   parameter int NCH = 4,
   parameter int DW  = 8,
   parameter int CHW = 2
) (
   input logic           clk,
   input logic           rst_n,
   input ps2tx_state_e   st,
   input logic [CHW-1:0] chan,
   input logic [CHW-1:0] ach,
   input logic [NCH-1:0] fall,
   input logic [NCH-1:0] en,
   input logic [NCH-1:0] clk_pull,
   input logic [NCH-1:0] dat_pull,
   input logic           sot,
   input logic           eot,
   input logic           sie,
   input logic           irq,
   input logic           wr,
   input logic [1:0]     addr,
   input logic [DW-1:0]  wdata
);
   p_one_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~clk_pull) <= 1);

   p_sot_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sot) |-> !clk_pull[ach]);

   p_hold_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACTIVE && en != '0 && !fall[chan]) |=> $stable(dat_pull[chan]));

   p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE) |-> !dat_pull[chan]);

   p_eot_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eot) |-> (&clk_pull));

   p_irq_sot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sot) && sie) |-> irq);

   p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_STAT && wdata[0] && st != ST_IDLE) |=> !sot);

   p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_INACT && en == '0) |=> (&clk_pull));
endmodule

bind ps2_host_tx ps2tx_chk #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .chan(chan), .ach(ach), .fall(fall),
   .en(en), .clk_pull(ps2_clk_pull), .dat_pull(ps2_dat_pull), .sot(sot),
   .eot(eot), .sie(sie), .irq(irq), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata)
);

// File: tb/tb_ps2_host_tx.sv
`timescale 1ns/1ps
module tb_ps2_host_tx;
   localparam int NCH = 4;
   localparam int DW  = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] dev_clk = '1;
   logic [NCH-1:0] dev_low = '0;
   logic [NCH-1:0] clk_in, dat_in, clk_pull, dat_pull;
   logic           reg_wr = 1'b0;
   logic [1:0]     reg_addr = 2'd0;
   logic [DW-1:0]  reg_wdata = '0;
   logic [DW-1:0]  reg_rdata;
   logic           irq;
   int             checks = 0;
   int             fails = 0;

   always #4 clk = ~clk;

   assign clk_in = ~clk_pull & dev_clk;
   assign dat_in = ~dat_pull & ~dev_low;

   ps2_host_tx #(.NCH(NCH), .DW(DW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .ps2_clk_i(clk_in), .ps2_dat_i(dat_in),
      .ps2_clk_pull(clk_pull), .ps2_dat_pull(dat_pull), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic dev_edge(input int c);
      dev_clk[c] = 1'b0;
      wait_cyc(6);
   endtask

   task automatic dev_rise(input int c);
      dev_clk[c] = 1'b1;
      wait_cyc(8);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] v;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(3);

      // R1 reset state
      chk(clk_pull == 4'hF, "R1 clocks", int'(clk_pull), 15);
      chk(dat_pull == 4'h0, "R1 data", int'(dat_pull), 0);
      rd(2'd3, v);
      chk(v == 8'h00, "R1 status", int'(v), 0);

      // R3 zero / multiple enables ignored
      wr(2'd1, 8'h03);
      wait_cyc(4);
      chk(clk_pull == 4'hF, "R3 two enables", int'(clk_pull), 15);
      wr(2'd1, 8'h0C);
      wait_cyc(4);
      chk(clk_pull == 4'hF, "R3 two enables b", int'(clk_pull), 15);
      wr(2'd1, 8'h00);
      wait_cyc(4);
      chk(clk_pull == 4'hF, "R3 zero enables", int'(clk_pull), 15);

      // R4 falling edge with data high starts nothing
      wr(2'd0, 8'h5A);
      wr(2'd1, 8'h01);
      wait_cyc(4);
      dev_edge(0);
      rd(2'd3, v);
      chk(v[0] == 1'b0, "R4 no start with data high", int'(v[0]), 0);
      chk(dat_pull[0] == 1'b0, "R4 data stays released", int'(dat_pull[0]), 0);
      chk(clk_pull == 4'hE, "R4 still requesting", int'(clk_pull), 14);
      dev_rise(0);
      wr(2'd1, 8'h00);

      // R12 abort mid-byte on channel 1
      wr(2'd2, 8'h0D);
      wr(2'd1, 8'h02);
      wait_cyc(4);
      for (int k = 0; k < 3; k++) begin
         dev_edge(1);
         dev_rise(1);
      end
      wr(2'd1, 8'h00);
      wait_cyc(2);
      chk(clk_pull == 4'hF, "R12 abort clocks low", int'(clk_pull), 15);
      chk(dat_pull == 4'h0, "R12 abort data released", int'(dat_pull), 0);
      wr(2'd3, 8'h03);
      rd(2'd3, v);
      chk(v[1:0] == 2'b00, "R11 flags cleared", int'(v[1:0]), 0);

      // full byte sweep
      for (int b = 0; b < 256; b++) begin
         int       c;
         logic     ackv, sie, eie, exp_bit, par;
         logic [7:0] by;
         by   = 8'(b);
         c    = b % NCH;
         ackv = by[2];
         sie  = by[0];
         eie  = by[5] ^ by[1];
         par  = ~^by;

         wr(2'd0, by);
         wr(2'd2, 8'(4'hF & ~(4'h1 << c)));
         chk(dat_pull[c] == 1'b1, "R2 data pulled", int'(dat_pull[c]), 1);
         chk(clk_pull == 4'hF, "R2 clocks held", int'(clk_pull), 15);
         wr(2'd1, 8'((1 << c) | (int'(sie) << 4) | (int'(eie) << 5)));
         wait_cyc(4);
         chk(clk_pull == 4'(~(4'h1 << c)), "R3 one clock released",
             int'(clk_pull), int'(4'(~(4'h1 << c))));

         for (int k = 1; k <= 11; k++) begin
            if (k == 11) dev_low[c] = ackv;
            dev_edge(c);
            if (k <= 8) exp_bit = by[k-1];
            else if (k == 9) exp_bit = par;
            else exp_bit = 1'b1;
            if (k == 1) begin
               chk(~dat_pull[c] == exp_bit, "R5 bit0", int'(~dat_pull[c]), int'(exp_bit));
               rd(2'd3, v);
               chk(v[0] == 1'b1 && v[4:3] == 2'(c), "R5 start flag/channel",
                   int'(v), int'({2'(c), 3'b001}));
               chk(irq == sie, "R10 start irq", int'(irq), int'(sie));
               wr(2'd2, 8'h0F);
            end else if (k <= 8) begin
               chk(~dat_pull[c] == exp_bit, "R6 data bit", int'(~dat_pull[c]), int'(exp_bit));
            end else if (k == 9) begin
               chk(~dat_pull[c] == exp_bit, "R7 parity", int'(~dat_pull[c]), int'(exp_bit));
            end else if (k == 10) begin
               chk(~dat_pull[c] == 1'b1, "R8 stop", int'(~dat_pull[c]), 1);
            end
            dev_rise(c);
         end
         dev_low[c] = 1'b0;

         chk(clk_pull == 4'hF, "R9 clocks low", int'(clk_pull), 15);
         chk(dat_pull[c] == 1'b0, "R8 line released", int'(dat_pull[c]), 0);
         rd(2'd3, v);
         chk(v[1] == 1'b1 && v[2] == ackv, "R9 end flag/ack",
             int'(v[2:1]), int'({ackv, 1'b1}));
         chk(irq == (sie | eie), "R10 irq both", int'(irq), int'(sie | eie));
         wr(2'd3, 8'h01);
         chk(irq == eie, "R11 start cleared irq", int'(irq), int'(eie));
         wr(2'd3, 8'h02);
         rd(2'd3, v);
         chk(v[1:0] == 2'b00 && irq == 1'b0, "R11 all cleared", int'(v[1:0]), 0);
         wr(2'd1, 8'h00);
         wait_cyc(2);
         chk(clk_pull == 4'hF, "R12 back to inactive", int'(clk_pull), 15);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule